// File: doc/BRIEF.md
# Residue-Split First-Order Product Stage

This combinational stage forms a first approximation of the product of two unsigned operands without converting them to logarithms. Each operand is split into its most significant set bit, at position k, and the remainder below that bit. The approximate product is the sum of three terms:

- a single one placed at position ka+kb;
- the remainder of A shifted left by kb;
- the remainder of B shifted left by ka.

The one term it leaves out is the product of the two remainders. That omitted term is the whole error of the stage, and it is never negative.

Both remainders are outputs of the stage. A downstream stage of the same kind can therefore take them as its operands and compute a correction term. A zero flag marks the case where either operand is zero. In that case the product and both remainders are held at zero.

Top module: `lmul_p0_stage`

## Requirements
- R1: For nonzero operands, `p0` equals 2^(ka+kb) + (res1 << kb) + (res2 << ka), where ka and kb are the bit positions of the highest set bit of `op_a` and `op_b`, and the sum is 2W bits wide.
- R2: For nonzero `op_a`, `res1` equals `op_a` with only its highest set bit cleared.
- R3: For nonzero `op_b`, `res2` equals `op_b` with only its highest set bit cleared.
- R4: `zero` is 1 exactly when `op_a` or `op_b` is zero, and 0 otherwise.
- R5: When `zero` is 1, `p0`, `res1` and `res2` are all zero.
- R6: For every operand pair, op_a*op_b == p0 + res1*res2, computed at 2W bits. As a consequence, `p0` never exceeds the true product.
- R7: If either operand is a power of two, `p0` equals the exact product.
- R8: With both operands all ones, `p0` equals 2^(2W-2) + 2^(2W-1) - 2^W. For W=16 this is 0xBFFF0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| p0 | output | 2W | First-order approximate product |
| res1 | output | W | op_a with its highest set bit removed |
| res2 | output | W | op_b with its highest set bit removed |
| zero | output | 1 | High when either operand is zero |

## Verification
Two functions meet in the same evaluation when one operand is zero and the other is not.

- The leading-one split of the nonzero operand still produces a remainder and a shift.
- The zero handling must override that split and clear all three data outputs.

The bench provokes this case with a zero paired with all-ones, with powers of two and with pseudo-random values, on either side. It judges the outputs against a behavioural model that clears everything whenever the flag is set. The other overlap is exactness on power-of-two operands. Here the remainder is zero, and the product must match the true product while the general formula also holds.

// File: rtl/lmul_pkg.sv
package lmul_pkg;
  parameter int unsigned LMUL_DEF_W = 16;
endpackage

// File: rtl/lmul_lod.sv
module lmul_lod #(
  parameter int W  = 16,
  parameter int KW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  output logic [KW-1:0] pos,
  output logic [W-1:0]  rem,
  output logic          nil
);
  // priority encoder: last set bit scanned upward wins
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) pos = KW'(i);
    end
    nil = (val == '0);
    rem = val & ~(W'(1) << pos);
  end

  always_comb begin
    if (!$isunknown(val) && !nil) begin
      AST_LOD_SPLIT: assert (((rem | (W'(1) << pos)) == val) && (rem < (W'(1) << pos)))
        else $error("leading-one split broken"); // R2
    end
  end
endmodule

// File: rtl/lmul_shl.sv
module lmul_shl #(
  parameter int IW = 16,
  parameter int OW = 32,
  parameter int AW = 4
) (
  input  logic [IW-1:0] din,
  input  logic [AW-1:0] amt,
  output logic [OW-1:0] dout
);
  logic [OW-1:0] stg [AW+1];

  assign stg[0] = OW'(din);

  for (genvar s = 0; s < AW; s++) begin : g_stage
    assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
  end

  assign dout = stg[AW];
endmodule

// File: rtl/lmul_dec.sv
module lmul_dec #(
  parameter int SW = 5,
  parameter int OW = 32
) (
  input  logic [SW-1:0] idx,
  output logic [OW-1:0] hot
);
  for (genvar i = 0; i < OW; i++) begin : g_bit
    assign hot[i] = (idx == SW'(i));
  end

  always_comb begin
    if (!$isunknown(idx) && (int'(idx) < OW)) begin
      AST_DEC_ONEHOT: assert ($countones(hot) == 1)
        else $error("decoder not one-hot"); // R1
    end
  end
endmodule

// File: rtl/lmul_p0_stage.sv
module lmul_p0_stage
  import lmul_pkg::*;
#(
  parameter int W = LMUL_DEF_W
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] p0,
  output logic [W-1:0]   res1,
  output logic [W-1:0]   res2,
  output logic           zero
);
  localparam int PW = 2 * W;
  localparam int KW = $clog2(W);
  localparam int SW = KW + 1;

  logic [KW-1:0] ka, kb;
  logic [W-1:0]  ra, rb;
  logic          za, zb;
  logic [PW-1:0] sh_a, sh_b, lead;
  logic [SW-1:0] ksum;

  lmul_lod #(.W(W), .KW(KW)) u_lod_a (.val(op_a), .pos(ka), .rem(ra), .nil(za));
  lmul_lod #(.W(W), .KW(KW)) u_lod_b (.val(op_b), .pos(kb), .rem(rb), .nil(zb));

  // residue of A moves by B's leading-one position and vice versa
  lmul_shl #(.IW(W), .OW(PW), .AW(KW)) u_shl_a (.din(ra), .amt(kb), .dout(sh_a));
  lmul_shl #(.IW(W), .OW(PW), .AW(KW)) u_shl_b (.din(rb), .amt(ka), .dout(sh_b));

  assign ksum = SW'(ka) + SW'(kb);

  lmul_dec #(.SW(SW), .OW(PW)) u_dec (.idx(ksum), .hot(lead));

  always_comb begin
    zero = za | zb;
    if (zero) begin
      p0   = '0;
      res1 = '0;
      res2 = '0;
    end else begin
      p0   = lead + sh_a + sh_b;
      res1 = ra;
      res2 = rb;
    end
  end

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      AST_ERR_EXACT: assert ((PW'(op_a) * PW'(op_b)) == (p0 + PW'(res1) * PW'(res2)))
        else $error("residual error mismatch"); // R6
      AST_ZERO_FLAG: assert (zero == ((op_a == '0) || (op_b == '0)))
        else $error("zero flag wrong"); // R4
      AST_ZERO_CLEAR: assert (!zero || ((p0 == '0) && (res1 == '0) && (res2 == '0)))
        else $error("outputs not cleared"); // R5
      AST_RES_BELOW: assert (zero || ((res1 < op_a) && (res2 < op_b)))
        else $error("residue not below operand"); // R2
    end
  end
endmodule

// File: tb/tb_lmul_p0_stage.sv
module tb_lmul_p0_stage;
  localparam int W = 16;
  localparam int PW = 2 * W;
  localparam longint unsigned MAXV = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [PW-1:0] p0;
  logic [W-1:0] res1, res2;
  logic zero;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lmul_p0_stage #(.W(W)) dut (
    .op_a(op_a), .op_b(op_b), .p0(p0), .res1(res1), .res2(res2), .zero(zero)
  );

  function automatic int msb(longint unsigned v);
    int r = 0;
    for (int i = 0; i < W; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit is_pow2(longint unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%0h b=%0h actual=%0h expected=%0h", req, op_a, op_b, act, exp);
    end
  endtask

  // reference model compared on every clock; inputs change on negedge
  always @(posedge clk) begin
    if (rst_n && !done) begin : cmp
      longint unsigned a, b, ra, rb, ep, prod;
      int ka, kb;
      bit z;
      a = op_a; b = op_b;
      z = (a == 0) || (b == 0);
      ka = msb(a); kb = msb(b);
      ra = z ? 0 : a - (64'd1 << ka);
      rb = z ? 0 : b - (64'd1 << kb);
      ep = z ? 0 : (64'd1 << (ka + kb)) + (ra << kb) + (rb << ka);
      prod = a * b;
      chk("R4", zero, z);
      if (z) begin
        chk("R5 p0", p0, 0);
        chk("R5 res1", res1, 0);
        chk("R5 res2", res2, 0);
      end else begin
        chk("R1", p0, ep);
        chk("R2", res1, ra);
        chk("R3", res2, rb);
      end
      chk("R6", prod - longint'(p0), longint'(res1) * longint'(res2));
      if (is_pow2(a) || is_pow2(b)) chk("R7", p0, prod);
      if (a == MAXV && b == MAXV)
        chk("R8", p0, (64'd1 << (PW - 2)) + (64'd1 << (PW - 1)) - (64'd1 << W));
    end
  end

  task automatic put(longint unsigned a, longint unsigned b);
    @(negedge clk);
    op_a = W'(a);
    op_b = W'(b);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    put(0, 0);                   // reset-state style: zero inputs, R4 R5
    put(0, MAXV); put(MAXV, 0);  // zero override with nonzero partner, R5
    put(0, 16'h1234); put(16'h8000, 0);
    put(1, 1); put(1, MAXV); put(MAXV, 1);  // R7
    put(MAXV, MAXV);             // R8
    put(3, 3); put(16'h00FF, 16'h0F0F); put(16'h8001, 16'h8001);
    for (int i = 0; i < W; i++) begin
      put(64'd1 << i, 16'h5A5A);           // R7
      put(16'hC3C3, 64'd1 << (W - 1 - i));
      put((64'd1 << i) | 1, MAXV >> i);
    end
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[W-2:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      put(lf, {lf[7:0], lf[15:8]} ^ 16'h3C5A);
      if (i % 97 == 0) put(lf, 0);
    end
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule